// File: doc/BRIEF.md
# Receive Alarm Event Latch

This block gathers the alarm and error events of a T1 receive framer into one 16-bit sticky word that a host reads through a simple bus. The upper byte records overflows reported by eight error counters. Bits 5 to 1 record one-cycle pulses from five error detectors. Bits 7 and 6 record any change, in either direction, of two out-of-sync status levels. Bit 0 records loss of signal. A built-in run counter raises that bit once a run of received zeros reaches a selectable length.

A read is a one-cycle strobe with an address. A strobe at either of two aliased addresses loads the current word onto the read-data port and clears the latch in the same edge. An event that arrives during that read edge is kept for the next read. A strobe at any other address leaves both the latch and the read-data port untouched.

Top module: `alm_event_latch`

## Requirements
- R1: After synchronous reset, the latch word and `rd_data` are all zero, and a first read returns 0x0000.
- R2: A one-cycle pulse on `ovf_evt[k]` sets latch bit 8+k. Bit 15 (k=7) is the framing-bit counter and bit 8 (k=0) is the multiframe out-of-frame counter.
- R3: A one-cycle pulse on `err_evt[k]` sets latch bit 1+k. k=4 is framing-bit error, 3 is frame-alignment change, 2 is severely errored frame, 1 is AIS and 0 is CRC error.
- R4: A change of `sync_lvl[1]` sets bit 7 and a change of `sync_lvl[0]` sets bit 6. A rise and a fall both count.
- R5: Sync levels held steady through reset and afterwards cause no event.
- R6: With `los_short`=0, the 192nd consecutive received zero sets bit 0 and 191 zeros do not. With `los_short`=1, the limit is 32 zeros.
- R7: A received one (`rx_valid`=1, `rx_bit`=1) restarts the zero run. Cycles with `rx_valid`=0 neither count nor break the run.
- R8: Bit 0 is set only once per run. Further zeros after the limit do not set it again until a one has been received.
- R9: A strobe at `ADDR_PRI` or at `ADDR_ALT` returns the latch word on `rd_data` on the next cycle and clears the latch.
- R10: A strobe at any other address changes neither the latch nor `rd_data`.
- R11: An event that coincides with a clearing read is not seen by that read. It stays set and appears on the next read.
- R12: Latched bits stay set over any number of idle cycles until a clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_evt | input | 8 | Counter-overflow pulses, to bits 15:8 |
| err_evt | input | 5 | Detector event pulses, to bits 5:1 |
| sync_lvl | input | 2 | Out-of-sync status levels: [1] terminal frame, [0] multiframe |
| rx_valid | input | 1 | Qualifies `rx_bit` |
| rx_bit | input | 1 | Received data bit |
| los_short | input | 1 | 1 selects a 32-zero limit, 0 selects 192 |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Word captured by the last aliased read |

## Verification
The assertions assume that event inputs are single-cycle pulses, that `rd_stb` is a single-cycle pulse, and that `los_short` stays constant during a zero run. The bench drives every input on the falling clock edge and holds each pulse for exactly one cycle. It changes `los_short` only directly after a received one. Read strobes are kept apart from event pulses, except in the one test that deliberately makes them coincide.

// File: rtl/alm_latch_pkg.sv
package alm_latch_pkg;
  localparam int WORD_W  = 16;
  localparam int OVF_N   = 8;
  localparam int ERR_N   = 5;
  localparam int SYNC_N  = 2;
  localparam int LOS_POS = 0;
  localparam int ERR_LO  = 1;
  localparam int SYNC_LO = 6;
  localparam int OVF_LO  = 8;

  // Zero-run limit picked by the short-run select.
  function automatic int unsigned run_limit(input logic short_sel,
                                            input int unsigned long_n,
                                            input int unsigned short_n);
    return short_sel ? short_n : long_n;
  endfunction

  // Assemble the per-cycle set vector in bit order of the latch word.
  function automatic logic [WORD_W-1:0] set_word(input logic [OVF_N-1:0]  ovf,
                                                 input logic [SYNC_N-1:0] chg,
                                                 input logic [ERR_N-1:0]  err,
                                                 input logic              los);
    return {ovf, chg, err, los};
  endfunction
endpackage

// File: rtl/alm_sync_edge.sv
module alm_sync_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] chg
);
  logic [N-1:0] prev_q;

  // The copy tracks the level during reset as well, so a steady level
  // produces no change once reset is released.
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      always_ff @(posedge clk) prev_q[gi] <= lvl[gi];
      assign chg[gi] = lvl[gi] ^ prev_q[gi];
    end
  endgenerate
endmodule

// File: rtl/alm_zero_run.sv
module alm_zero_run
  import alm_latch_pkg::*;
#(
  parameter int LONG_RUN  = 192,
  parameter int SHORT_RUN = 32,
  localparam int CNT_W    = $clog2(LONG_RUN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_valid,
  input  logic rx_bit,
  input  logic short_sel,
  output logic run_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit   = CNT_W'(run_limit(short_sel, LONG_RUN, SHORT_RUN));
  assign run_evt = rx_valid && !rx_bit && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (rx_valid) begin
      if (rx_bit)
        cnt_q <= '0;
      else if (cnt_q < limit)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(LONG_RUN));
  p_one_restarts_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid && rx_bit |=> cnt_q == '0);
  p_idle_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(cnt_q));
  p_single_evt_r8: assert property (@(posedge clk) disable iff (rst)
    run_evt |=> !run_evt);
endmodule

// File: rtl/alm_sticky_bits.sv
module alm_sticky_bits #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q
);
  // Set wins over clear, so an event in the read edge survives.
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (clr_i) q <= set_i;
    else            q <= q | set_i;
  end

  p_sticky_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (q & $past(q)) == $past(q));
  p_clear_keeps_new_r11: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> q == $past(set_i));
  p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q & $past(set_i)) == $past(set_i));
endmodule

// File: rtl/alm_event_latch.sv
module alm_event_latch
  import alm_latch_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_PRI  = 8'h14,
  parameter logic [ADDR_W-1:0] ADDR_ALT  = 8'h1C,
  parameter int                LONG_RUN  = 192,
  parameter int                SHORT_RUN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        ovf_evt,
  input  logic [4:0]        err_evt,
  input  logic [1:0]        sync_lvl,
  input  logic              rx_valid,
  input  logic              rx_bit,
  input  logic              los_short,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data
);
  logic [SYNC_N-1:0] sync_chg;
  logic              los_evt;
  logic              rd_hit;
  logic [WORD_W-1:0] set_vec;
  logic [WORD_W-1:0] latch_q;

  alm_sync_edge #(.N(SYNC_N)) u_sync (
    .clk (clk),
    .lvl (sync_lvl),
    .chg (sync_chg)
  );

  alm_zero_run #(.LONG_RUN(LONG_RUN), .SHORT_RUN(SHORT_RUN)) u_los (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .short_sel (los_short),
    .run_evt   (los_evt)
  );

  assign set_vec = set_word(ovf_evt, sync_chg, err_evt, los_evt);
  assign rd_hit  = rd_stb && (rd_addr == ADDR_PRI || rd_addr == ADDR_ALT);

  alm_sticky_bits #(.W(WORD_W)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .set_i (set_vec),
    .clr_i (rd_hit),
    .q     (latch_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_hit) rd_data <= latch_q;
  end

  p_read_old_r9: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> rd_data == $past(latch_q));
  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    rd_stb && rd_addr != ADDR_PRI && rd_addr != ADDR_ALT |=> $stable(rd_data));
  p_sync_lands_r4: assert property (@(posedge clk) disable iff (rst)
    sync_chg != '0 |=> (latch_q[7:6] & $past(sync_chg)) == $past(sync_chg));
  p_los_lands_r6: assert property (@(posedge clk) disable iff (rst)
    los_evt |=> latch_q[LOS_POS]);
endmodule

// File: tb/tb_alm_event_latch.sv
module tb_alm_event_latch;
  localparam logic [7:0] A_PRI = 8'h14;
  localparam logic [7:0] A_ALT = 8'h1C;
  localparam logic [7:0] A_OTH = 8'h15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ovf_evt = '0;
  logic [4:0]  err_evt = '0;
  logic [1:0]  sync_lvl = 2'b11;
  logic        rx_valid = 1'b0;
  logic        rx_bit = 1'b0;
  logic        los_short = 1'b0;
  logic        rd_stb = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alm_event_latch dut (
    .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .err_evt(err_evt),
    .sync_lvl(sync_lvl), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .los_short(los_short), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  // Fields: [29:22] ovf, [21:17] err, [16] use alias, [15:0] expected
  localparam logic [29:0] VEC [9] = '{
    {8'h80, 5'h00, 1'b0, 16'h8000},
    {8'h40, 5'h00, 1'b1, 16'h4000},
    {8'h20, 5'h00, 1'b0, 16'h2000},
    {8'h10, 5'h00, 1'b1, 16'h1000},
    {8'h0F, 5'h00, 1'b0, 16'h0F00},
    {8'h00, 5'h10, 1'b0, 16'h0020},
    {8'h00, 5'h08, 1'b1, 16'h0010},
    {8'h00, 5'h07, 1'b0, 16'h000E},
    {8'hA5, 5'h15, 1'b1, 16'hA52A}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] o, input logic [4:0] e);
    ovf_evt = o; err_evt = e;
    @(negedge clk);
    ovf_evt = '0; err_evt = '0;
  endtask

  task automatic do_read(input logic [7:0] a);
    rd_stb = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic send(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_bit = b;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_bit = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rd_data", rd_data, 16'h0000);
    do_read(A_PRI);
    check("R1/R5 first read after reset", rd_data, 16'h0000);

    foreach (VEC[i]) begin
      pulse(VEC[i][29:22], VEC[i][21:17]);
      do_read(VEC[i][16] ? A_ALT : A_PRI);
      check("R2/R3/R9 vector read", rd_data, VEC[i][15:0]);
      do_read(VEC[i][16] ? A_PRI : A_ALT);
      check("R9 cleared after read", rd_data, 16'h0000);
    end

    // R4: both directions of each sync level
    sync_lvl[1] = 1'b0; @(negedge clk);
    do_read(A_PRI); check("R4 terminal sync fall", rd_data, 16'h0080);
    sync_lvl[1] = 1'b1; @(negedge clk);
    do_read(A_ALT); check("R4 terminal sync rise", rd_data, 16'h0080);
    sync_lvl[0] = 1'b0; @(negedge clk);
    do_read(A_PRI); check("R4 multiframe sync fall", rd_data, 16'h0040);
    repeat (4) @(negedge clk);
    do_read(A_PRI); check("R5 steady level quiet", rd_data, 16'h0000);

    // R12: sticky over idle time
    pulse(8'h01, 5'h00);
    repeat (20) @(negedge clk);
    do_read(A_PRI); check("R12 held over idle", rd_data, 16'h0100);

    // R10: read at other address has no effect
    pulse(8'h02, 5'h00);
    do_read(A_OTH); check("R10 miss keeps rd_data", rd_data, 16'h0100);
    do_read(A_PRI); check("R10 latch kept after miss", rd_data, 16'h0200);

    // R11: event coincides with clearing read
    err_evt = 5'h01; rd_stb = 1'b1; rd_addr = A_PRI;
    @(negedge clk);
    err_evt = '0; rd_stb = 1'b0;
    check("R11 read returns old word", rd_data, 16'h0000);
    do_read(A_ALT); check("R11 event kept", rd_data, 16'h0002);

    // R6: long limit
    send(1'b1, 1); send(1'b0, 191);
    do_read(A_PRI); check("R6 191 zeros no LOS", rd_data, 16'h0000);
    send(1'b0, 1);
    do_read(A_PRI); check("R6 192nd zero sets LOS", rd_data, 16'h0001);
    // R8: no re-trigger within a run
    send(1'b0, 250);
    do_read(A_PRI); check("R8 no second LOS in run", rd_data, 16'h0000);

    // R6/R7: short limit, one restarts, idle cycles ignored
    send(1'b1, 1); los_short = 1'b1;
    send(1'b0, 20); send(1'b1, 1); send(1'b0, 31);
    do_read(A_PRI); check("R7 one restarts run", rd_data, 16'h0000);
    rx_valid = 1'b0; rx_bit = 1'b0; repeat (5) @(negedge clk);
    do_read(A_PRI); check("R7 idle does not count", rd_data, 16'h0000);
    send(1'b0, 1);
    do_read(A_PRI); check("R6 32nd zero sets LOS", rd_data, 16'h0001);
    send(1'b1, 1); send(1'b0, 32);
    do_read(A_ALT); check("R8 new run after one sets LOS", rd_data, 16'h0001);

    // R1: reset mid-state clears everything
    pulse(8'hFF, 5'h1F);
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    check("R1 reset clears rd_data", rd_data, 16'h0000);
    do_read(A_PRI); check("R1 reset clears latch", rd_data, 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule